// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Faults

This block sits between dispatch and the architectural register file of an out-of-order core. It lets results be produced in any order while register state changes only in program order. Each dispatched instruction claims a slot at the tail of a circular queue and gets that slot's tag. An execution unit later uses the tag to deposit a result, or a fault mark, in the slot.

The oldest slot leaves the queue only once it has been completed. A clean result is copied into the architectural file. A faulting result instead discards every slot, including younger ones that already finished, and raises a one-cycle handler-start pulse. This keeps exceptions precise.

A read port resolves source operands. It returns the newest in-flight producer of a register: its value when that value is ready, or its tag when it is not. When no slot names the register, the port returns the architectural file's value.

Top module: `reorder_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` is 1, `commit_valid` and `handler_start` are 0, and every architectural register reads as 0.
- R2: An accepted allocation takes the slot whose tag is shown on `alloc_tag`. Tags advance by one for each accepted allocation and wrap from DEPTH-1 to 0.
- R3: With DEPTH slots occupied, `alloc_ready` is 0. An `alloc_valid` in that state creates no slot and does not move `alloc_tag`.
- R4: Writebacks may arrive for any occupied slot in any order. Slots retire strictly oldest first, one per cycle. `commit_valid`, `commit_reg` and `commit_value` show the retiring slot, and nothing retires while the oldest slot is incomplete.
- R5: A writeback to the oldest slot makes it retire no earlier than the following cycle. `commit_valid` stays 0 in the writeback cycle.
- R6: A lookup returns the youngest occupied slot naming `lookup_reg`. If that slot is incomplete, it reports `lookup_pending`=1 with the slot's tag. If that slot is complete, it reports `lookup_pending`=0 with its value. With no match it reports `lookup_pending`=0 and the architectural value.
- R7: A clean retirement writes its value into the architectural register it names.
- R8: A completed faulting oldest slot never commits. `handler_start` is 1 for exactly the one cycle after that slot is seen. At the end of that cycle the queue becomes empty with tags restarting at 0, and no architectural register is written by the discarded slots.
- R9: During the `handler_start` cycle, `alloc_ready` is 0. Allocations and writebacks offered in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request for a new slot |
| alloc_dest | input | AREG_W | Destination register of the new instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Tag of the slot the next allocation takes |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | TAG_W | Slot being completed |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Result raised an exception |
| lookup_reg | input | AREG_W | Source register to resolve |
| lookup_pending | output | 1 | Newest producer has not completed |
| lookup_tag | output | TAG_W | Tag of the newest producer |
| lookup_value | output | DATA_W | Operand value when not pending |
| commit_valid | output | 1 | Oldest slot retires cleanly this cycle |
| commit_reg | output | AREG_W | Register being written |
| commit_value | output | DATA_W | Value being written |
| handler_start | output | 1 | One-cycle pulse that starts the exception handler |

## Verification
A corrupted head pointer or completion bit shows up at once on `commit_valid`/`commit_reg`, in the same cycle, as a retirement out of order or a missing one. A bad tail or occupancy count appears on `alloc_tag` and `alloc_ready` at the next allocation. A stale slot that survived a flush surfaces through `lookup_pending` or a wrong architectural value on the first lookup of the register concerned. A fault that acts early or twice is visible as a second `handler_start` pulse, or as a commit of a younger instruction, within one cycle of the faulting slot reaching the head.

// File: rtl/reorder_queue.sv
module reorder_queue #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_fault,
  input  logic [AREG_W-1:0] lookup_reg,
  output logic              lookup_pending,
  output logic [TAG_W-1:0]  lookup_tag,
  output logic [DATA_W-1:0] lookup_value,
  output logic              commit_valid,
  output logic [AREG_W-1:0] commit_reg,
  output logic [DATA_W-1:0] commit_value,
  output logic              handler_start
);
  localparam int NREG  = 1 << AREG_W;
  localparam int CNT_W = TAG_W + 1;
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [DEPTH-1:0]  busy, done, fault;
  logic [AREG_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [DATA_W-1:0] arf    [NREG];
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              flush_q;

  wire head_ready = (count != '0) && done[head];
  wire do_retire  = head_ready && !fault[head] && !flush_q;
  wire do_trap    = head_ready &&  fault[head] && !flush_q;
  wire do_alloc   = alloc_valid && alloc_ready;
  wire do_wb      = wb_valid && !flush_q && busy[wb_tag];

  assign alloc_ready   = (count != CNT_W'(DEPTH)) && !flush_q;
  assign alloc_tag     = tail;
  assign commit_valid  = do_retire;
  assign commit_reg    = dest_q[head];
  assign commit_value  = val_q[head];
  assign handler_start = flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0; flush_q <= 1'b0;
      busy <= '0; done <= '0; fault <= '0;
    end else if (flush_q) begin
      head <= '0; tail <= '0; count <= '0; flush_q <= 1'b0;
      busy <= '0; done <= '0; fault <= '0;
    end else begin
      flush_q <= do_trap;
      if (do_alloc) begin
        busy[tail]  <= 1'b1;
        done[tail]  <= 1'b0;
        fault[tail] <= 1'b0;
        tail <= (tail == LAST) ? '0 : tail + 1'b1;
      end
      if (do_wb) begin
        done[wb_tag]  <= 1'b1;
        fault[wb_tag] <= wb_fault;
      end
      if (do_retire) begin
        busy[head] <= 1'b0;
        head <= (head == LAST) ? '0 : head + 1'b1;
      end
      count <= count + CNT_W'(do_alloc) - CNT_W'(do_retire);
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) dest_q[tail] <= alloc_dest;
    if (do_wb)    val_q[wb_tag] <= wb_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) arf[r] <= '0;
    end else if (do_retire) begin
      arf[dest_q[head]] <= val_q[head];
    end
  end

  logic hit;
  always_comb begin
    hit = 1'b0;
    lookup_tag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int idx;
      idx = int'(head) + i;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (i < int'(count) && dest_q[idx] == lookup_reg) begin
        hit = 1'b1;
        lookup_tag = TAG_W'(idx);
      end
    end
  end
  assign lookup_pending = hit && !done[lookup_tag];
  assign lookup_value   = hit ? val_q[lookup_tag] : arf[lookup_reg];

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !alloc_ready);
  p_retire_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head == (($past(head) == LAST) ? '0 : $past(head) + 1'b1));
  p_wb_next_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_tag == head && !done[head]) |-> !commit_valid);
  p_trap_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_trap |=> (handler_start && !commit_valid));
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |=> (!handler_start && count == '0 && tail == '0));
  p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |-> !alloc_ready);
endmodule

// File: tb/tb_reorder_queue.sv
module tb_reorder_queue;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, wb_valid = 0, wb_fault = 0;
  logic [4:0] alloc_dest = 0, lookup_reg = 0;
  logic [2:0] wb_tag = 0;
  logic [DW-1:0] wb_value = 0;
  logic alloc_ready, lookup_pending, commit_valid, handler_start;
  logic [2:0] alloc_tag, lookup_tag;
  logic [DW-1:0] lookup_value, commit_value;
  logic [4:0] commit_reg;
  int ntests = 0, nfail = 0, hcount = 0;

  always #4 clk = ~clk;

  reorder_queue dut (.*);

  localparam logic [4:0]    T_DST [8] = '{5'd3, 5'd7, 5'd3, 5'd9, 5'd3, 5'd11, 5'd12, 5'd7};
  localparam logic [DW-1:0] T_VAL [8] = '{32'h11, 32'h2222, 32'h33, 32'h4444,
                                          32'h55, 32'h6666, 32'h77, 32'h8888};

  always @(negedge clk) if (rst_n && handler_start) hcount++;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(logic [4:0] r);
    lookup_reg = r; #1;
  endtask

  initial begin
    #800000;
    nfail++; ntests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 handler_start", handler_start, 0);
    look(5);
    chk("R1 arf value", lookup_value, 0);
    chk("R1 not pending", lookup_pending, 0);

    // table walk: fill, complete in reverse, retire in order
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); alloc_valid = 1; alloc_dest = T_DST[i]; #1;
      chk("R2 tag", alloc_tag, i);
      chk("R3 ready", alloc_ready, 1);
    end
    @(negedge clk); alloc_dest = 30; #1;
    chk("R3 full", alloc_ready, 0);
    look(3);
    chk("R6 pending", lookup_pending, 1);
    chk("R6 youngest tag", lookup_tag, 4);
    @(negedge clk); alloc_valid = 0; #1;
    look(30);
    chk("R3 refused not queued", lookup_pending, 0);
    chk("R3 tag unchanged", alloc_tag, 0);
    for (int j = 7; j >= 1; j--) begin
      @(negedge clk); wb_valid = 1; wb_tag = 3'(j); wb_value = T_VAL[j]; #1;
      chk("R4 head blocks", commit_valid, 0);
    end
    @(negedge clk); wb_tag = 0; wb_value = T_VAL[0]; #1;
    chk("R5 no same-cycle commit", commit_valid, 0);
    look(3);
    chk("R6 ready not pending", lookup_pending, 0);
    chk("R6 youngest value", lookup_value, T_VAL[4]);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); wb_valid = 0; #1;
      chk("R4 commit valid", commit_valid, 1);
      chk("R4 commit reg", commit_reg, T_DST[k]);
      chk("R4 commit value", commit_value, T_VAL[k]);
    end
    @(negedge clk); #1;
    chk("R4 drained", commit_valid, 0);
    look(3);  chk("R7 arf r3", lookup_value, T_VAL[4]);
    look(7);  chk("R7 arf r7", lookup_value, T_VAL[7]);
    look(9);  chk("R7 arf r9", lookup_value, T_VAL[3]);

    // wrap-around of tags
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); alloc_valid = 1; alloc_dest = 5'(13 + i);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); alloc_valid = 0; wb_valid = 1; wb_tag = 3'(i); wb_value = 32'(500 + i);
    end
    @(negedge clk); wb_valid = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); alloc_valid = 1; alloc_dest = 5'(24 + i); #1;
      chk("R2 wrap tag", alloc_tag, (5 + i) % 8);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); alloc_valid = 0; wb_valid = 1; wb_tag = 3'((5 + i) % 8); wb_value = 32'(900 + i);
    end
    @(negedge clk); wb_valid = 0;
    repeat (7) @(negedge clk);
    #1;
    look(13); chk("R7 arf r13", lookup_value, 500);
    look(27); chk("R7 arf r27", lookup_value, 903);

    // faulting divide followed by two quick ops
    @(negedge clk); alloc_valid = 1; alloc_dest = 20; #1; chk("R2 div tag", alloc_tag, 2);
    @(negedge clk); alloc_dest = 21;
    @(negedge clk); alloc_dest = 22;
    @(negedge clk); alloc_valid = 0; wb_valid = 1; wb_tag = 3; wb_value = 11;
    @(negedge clk); wb_tag = 4; wb_value = 5; #1;
    chk("R4 younger done, head not", commit_valid, 0);
    @(negedge clk); wb_tag = 2; wb_value = 0; wb_fault = 1; #1;
    chk("R8 no early pulse", handler_start, 0);
    @(negedge clk); wb_valid = 0; wb_fault = 0; #1;
    chk("R8 fault no commit", commit_valid, 0);
    chk("R8 pulse waits", handler_start, 0);
    @(negedge clk); alloc_valid = 1; alloc_dest = 29; wb_valid = 1; wb_tag = 3; wb_value = 77; #1;
    chk("R8 handler pulse", handler_start, 1);
    chk("R9 alloc blocked", alloc_ready, 0);
    chk("R8 no commit in flush", commit_valid, 0);
    @(negedge clk); alloc_valid = 0; wb_valid = 0; #1;
    chk("R8 pulse ends", handler_start, 0);
    chk("R8 tags restart", alloc_tag, 0);
    chk("R8 ready again", alloc_ready, 1);
    look(21); chk("R8 r21 untouched", lookup_value, 0); chk("R8 r21 not pending", lookup_pending, 0);
    look(22); chk("R8 r22 untouched", lookup_value, 0);
    look(20); chk("R8 r20 untouched", lookup_value, 0);
    look(29); chk("R9 alloc dropped", lookup_pending, 0);
    @(negedge clk); alloc_valid = 1; alloc_dest = 28;
    @(negedge clk); alloc_valid = 0; #1;
    look(28);
    chk("R9 wb dropped", lookup_pending, 1);
    chk("R9 new tag", lookup_tag, 0);
    repeat (5) @(negedge clk);
    chk("R8 single pulse", hcount, 1);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule